// File: doc/BRIEF.md
# Prescaled Up-Counting Interval Timer

A single timer channel on a plain 32-bit register bus. Once enabled, a counter `CNT_W` bits wide (28 by default) counts upward. It advances once every N bus-clock cycles, where N is a 16-bit prescale divisor. Software sets an end marker. When the next increment would make the count equal the marker, or would carry past the all-ones value, the count returns to zero and a wrap event is raised.

A mode bit selects what happens after a wrap. In one-shot mode the counter parks at zero. In free-running mode it keeps counting from zero. Each wrap event sets a sticky pending flag. Software clears the flag by writing one to it. The flag drives a level interrupt output through a mask bit.

Register access is a single-cycle strobe: a write takes effect on the clock edge where `bus_sel` and `bus_wr` are high. Reads are combinational from `bus_addr`. The bus carries no streamed data, so there is no valid/ready handshake and no back-pressure. Byte address bits [3:2] select one of four word registers:

| Offset | Register | Contents |
|---|---|---|
| 0x0 | end marker | value in bits [CNT_W-1:0] |
| 0x4 | live count | count value; read-only |
| 0x8 | control | run enable, mode, divisor |
| 0xC | interrupt | mask and pending flag |

Top module: `mm_upcount_timer`

## Requirements
- R1: After reset all four registers read 0 and `irq_o` is 0.
- R2: The end-marker register keeps only bits [CNT_W-1:0] and reads back with the upper bits zero. A write to offset 0x4 leaves the count unchanged.
- R3: Setting control bit 28 while the timer is disabled clears the count to 0 on that write edge. With divisor D (control bits [15:0]), the count n cycles after that edge equals floor(n/D).
- R4: A divisor of 0 advances the count every cycle, the same as a divisor of 1.
- R5: On the tick where the count would reach the end marker M, the count becomes 0 and a wrap event is raised. In free-running mode the count n cycles after a start is floor(n/D) mod M.
- R6: An increment from the all-ones count also wraps to 0 and raises a wrap event. This includes the case of an end marker of 0.
- R7: Control bit 24 selects the mode. A value of 0 (one-shot) stops the count at 0 after a wrap. A value of 1 (free-running) keeps counting.
- R8: A stopped one-shot counter stays at 0, and sets no further pending flag, until control bit 28 is cleared and then set again. Writing bit 28 as 1 again while it is already 1 does not restart the counter.
- R9: Clearing bit 28 holds the count and resets the prescale phase. After re-enabling, the first increment comes D cycles later.
- R10: Interrupt bit 16 is the pending flag. It sets on every wrap event whatever the mask holds. Writing 1 to bit 16 clears it. Writing 0 to bit 16 leaves it unchanged.
- R11: Interrupt bit 20 is the mask. `irq_o` is high exactly while both pending and mask are 1.
- R12: A write of 1 to bit 16 on the same edge as a wrap event leaves the pending flag set.
- R13: Undefined bits read 0. Control reads back bit 28 (enable), bit 24 (mode) and bits [15:0] (divisor). Interrupt reads back bits 20 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the count clock before prescaling |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | Write when high with `bus_sel` |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt (pending AND mask) |

## Verification
The bench uses an 8-bit counter so that the overflow path can be reached. It sweeps every end marker from 1 to 5 against divisors 1 to 3 in free-running mode and compares the count each cycle with floor(n/D) mod M. This separates prescaler errors from compare errors, and an off-by-one in the marker match from a missed wrap. Further patterns cover:
- a one-shot run followed by idle cycles, a redundant enable, and a true restart (stop-and-hold);
- a zero divisor;
- a zero marker that reaches all-ones overflow;
- a disable issued in the middle of a prescale phase;
- a clear that lands on the same edge as a wrap, which isolates the priority between event and clear in the pending flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  // word index taken from bus_addr[3:2]
  localparam logic [1:0] IDX_MARK = 2'd0;
  localparam logic [1:0] IDX_CNT  = 2'd1;
  localparam logic [1:0] IDX_CTRL = 2'd2;
  localparam logic [1:0] IDX_IRQ  = 2'd3;

  localparam int EN_BIT   = 28;
  localparam int MODE_BIT = 24;
  localparam int IE_BIT   = 20;
  localparam int PEND_BIT = 16;

  typedef enum logic {
    RUN_ONESHOT = 1'b0,
    RUN_FREE    = 1'b1
  } run_mode_e;
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int CNT_W = 28,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              pend,
  output logic [CNT_W-1:0]  marker,
  output logic              en,
  output run_mode_e         mode,
  output logic [DIV_W-1:0]  div,
  output logic              ie,
  output logic              start,
  output logic              clr_pend,
  output logic [BUS_W-1:0]  rdata
);
  logic [1:0] idx;
  logic       wr_mark, wr_ctrl, wr_irq;
  logic       unused_bits;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr_mark = bus_sel && bus_wr && (idx == IDX_MARK);
  assign wr_ctrl = bus_sel && bus_wr && (idx == IDX_CTRL);
  assign wr_irq  = bus_sel && bus_wr && (idx == IDX_IRQ);

  // a start only happens when enabling from the disabled state
  assign start    = wr_ctrl && bus_wdata[EN_BIT] && !en;
  assign clr_pend = wr_irq && bus_wdata[PEND_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      marker <= '0;
      en     <= 1'b0;
      mode   <= RUN_ONESHOT;
      div    <= '0;
      ie     <= 1'b0;
    end else begin
      if (wr_mark) marker <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl) begin
        en   <= bus_wdata[EN_BIT];
        mode <= run_mode_e'(bus_wdata[MODE_BIT]);
        div  <= bus_wdata[DIV_W-1:0];
      end
      if (wr_irq) ie <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_MARK: rdata[CNT_W-1:0] = marker;
      IDX_CNT:  rdata[CNT_W-1:0] = count;
      IDX_CTRL: begin
        rdata[EN_BIT]    = en;
        rdata[MODE_BIT]  = mode;
        rdata[DIV_W-1:0] = div;
      end
      default: begin
        rdata[IE_BIT]   = ie;
        rdata[PEND_BIT] = pend;
      end
    endcase
  end

  assign unused_bits = ^{bus_addr[1:0], bus_wdata};
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] PH_ONE = DIV_W'(1);

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] last;

  // divisor 0 behaves as divisor 1
  assign last = (div == '0) ? '0 : div - PH_ONE;
  assign tick = run && (phase == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (!run) phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + PH_ONE;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic             tick,
  input  run_mode_e        mode,
  input  logic [CNT_W-1:0] marker,
  output logic [CNT_W-1:0] count,
  output logic             halted,
  output logic             run,
  output logic             evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] nxt;
  logic             wrap;

  assign nxt  = count + CNT_ONE;
  assign wrap = (count == CNT_MAX) || (nxt == marker);
  assign run  = en && !halted;
  assign evt  = run && tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      halted <= 1'b0;
    end else if (start) begin
      count  <= '0;
      halted <= 1'b0;
    end else if (run && tick) begin
      if (wrap) begin
        count  <= '0;
        halted <= (mode == RUN_ONESHOT);
      end else begin
        count <= nxt;
      end
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic ie,
  output logic pend,
  output logic irq
);
  // a new event wins over a same-edge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (evt) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  assign irq = pend && ie;
endmodule

// File: rtl/mm_upcount_timer.sv
module mm_upcount_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 28,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0] marker_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  run_mode_e        mode_q;
  logic             en_q, ie_q, start, clr_pend;
  logic             halted_q, run, tick, evt, pend_q;

  tmr_regfile #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(cnt_q), .pend(pend_q),
    .marker(marker_q), .en(en_q), .mode(mode_q), .div(div_q), .ie(ie_q),
    .start(start), .clr_pend(clr_pend), .rdata(bus_rdata)
  );

  tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en_q), .tick(tick),
    .mode(mode_q), .marker(marker_q), .count(cnt_q), .halted(halted_q),
    .run(run), .evt(evt)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_pend), .ie(ie_q),
    .pend(pend_q), .irq(irq_o)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              en_q,
  input logic              halted,
  input logic [CNT_W-1:0]  count,
  input logic              pend,
  input logic              evt
);
  logic ctrl_wr, pend_clr;
  assign ctrl_wr  = bus_sel && bus_wr && (bus_addr[3:2] == IDX_CTRL);
  assign pend_clr = bus_sel && bus_wr && (bus_addr[3:2] == IDX_IRQ) && bus_wdata[PEND_BIT];

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[EN_BIT] && !en_q) |=> (count == '0)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !halted && !ctrl_wr) |=>
      (count == $past(count) || count == $past(count) + CNT_W'(1) || count == '0)); // R5
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_wr) |=> $stable(count)); // R9
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ctrl_wr) |=> ($stable(count) && halted)); // R8
  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(evt)); // R10
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !pend_clr) |=> pend); // R10
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend); // R12
endmodule

bind mm_upcount_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en_q(en_q),
  .halted(halted_q), .count(cnt_q), .pend(pend_q), .evt(evt)
);

// File: tb/mm_upcount_timer_tb.sv
module mm_upcount_timer_tb;
  localparam int CNT_W = 8;
  localparam logic [3:0]  A_MARK = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_IRQ = 4'hC;
  localparam logic [31:0] EN = 32'h1000_0000, FREE = 32'h0100_0000;
  localparam logic [31:0] IE = 32'h0010_0000, PEND = 32'h0001_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mm_upcount_timer #(.CNT_W(CNT_W), .DIV_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // entered just after a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, c0;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    rd(A_MARK, v); chk("R1 marker", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_IRQ, v);  chk("R1 irq reg", v, 0);
    chk("R1 irq_o", {31'b0, irq_o}, 0);

    // R5 / R3 / R10 sweep, free-running mode
    for (int m = 1; m <= 5; m++) begin
      for (int d = 1; d <= 3; d++) begin
        wr(A_CTRL, 0); wr(A_IRQ, PEND); wr(A_MARK, m);
        wr(A_CTRL, EN | FREE | d);
        for (int n = 1; n <= 2 * m * d + 1; n++) begin
          @(negedge clk);
          rd(A_CNT, v); chk("R5 free count", v, (n / d) % m);
          rd(A_IRQ, v);
          if (n == m * d - 1) chk("R10 pend before wrap", v, 0);
          if (n == m * d)     chk("R10 pend at wrap with mask 0", v, PEND);
        end
      end
    end

    // R4 divisor 0
    wr(A_CTRL, 0); wr(A_MARK, 10); wr(A_CTRL, EN | FREE);
    idle(4); rd(A_CNT, v); chk("R4 div0 count", v, 4);

    // R7 / R8 one-shot: marker 3, divisor 2
    wr(A_CTRL, 0); wr(A_IRQ, PEND); wr(A_MARK, 3); wr(A_CTRL, EN | 2);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      rd(A_CNT, v); chk("R7 oneshot count", v, (n < 6) ? n / 2 : 0);
    end
    rd(A_IRQ, v); chk("R7 oneshot pend", v, PEND);
    wr(A_IRQ, 0); rd(A_IRQ, v); chk("R10 write 0 keeps pend", v, PEND);
    wr(A_IRQ, PEND); idle(10);
    rd(A_IRQ, v); chk("R8 no second pend", v, 0);
    rd(A_CNT, v); chk("R8 stays at zero", v, 0);
    wr(A_CTRL, EN | 2); idle(4);
    rd(A_CNT, v); chk("R8 redundant enable no restart", v, 0);
    wr(A_CTRL, 0); wr(A_CTRL, EN | 2); idle(2);
    rd(A_CNT, v); chk("R8 restart after clear", v, 1);

    // R6 overflow with marker 0
    wr(A_CTRL, 0); wr(A_IRQ, PEND); wr(A_MARK, 0); wr(A_CTRL, EN | FREE | 1);
    idle(255);
    rd(A_CNT, v); chk("R6 count at all-ones", v, 255);
    rd(A_IRQ, v); chk("R6 no pend before overflow", v, 0);
    idle(1);
    rd(A_CNT, v); chk("R6 wrapped to zero", v, 0);
    rd(A_IRQ, v); chk("R6 pend on overflow", v, PEND);

    // R9 disable holds count, phase resets
    wr(A_CTRL, 0); wr(A_MARK, 100); wr(A_CTRL, EN | FREE | 3);
    idle(10); rd(A_CNT, v); chk("R3 div3 count", v, 3);
    wr(A_CTRL, 0); idle(5);
    rd(A_CNT, v); chk("R9 held after disable", v, 3);
    wr(A_CTRL, EN | FREE | 3); idle(2);
    rd(A_CNT, v); chk("R9 no early tick", v, 0);
    idle(1); rd(A_CNT, v); chk("R9 first tick after D", v, 1);

    // R11 mask
    wr(A_CTRL, 0); wr(A_IRQ, PEND); wr(A_MARK, 2); wr(A_CTRL, EN | 1);
    idle(3);
    chk("R11 masked irq_o", {31'b0, irq_o}, 0);
    wr(A_IRQ, IE);
    chk("R11 unmasked irq_o", {31'b0, irq_o}, 1);
    wr(A_IRQ, IE | PEND);
    chk("R11 cleared irq_o", {31'b0, irq_o}, 0);

    // R12 clear on the same edge as a wrap: marker 4, divisor 1
    wr(A_CTRL, 0); wr(A_IRQ, PEND); wr(A_MARK, 4); wr(A_CTRL, EN | FREE | 1);
    idle(7);
    wr(A_IRQ, PEND);
    rd(A_IRQ, v); chk("R12 event beats clear", v, PEND);
    wr(A_IRQ, PEND);
    rd(A_IRQ, v); chk("R12 later clear works", v, 0);

    // R13 readback of defined bits only
    wr(A_CTRL, 0); wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R13 ctrl readback", v, 32'h1100_FFFF);
    wr(A_IRQ, 32'hFFFF_FFFF);
    rd(A_IRQ, v); chk("R13 irq readback", v, 32'h0010_0000);
    wr(A_CTRL, 0); wr(A_IRQ, 0);

    // R2 marker masking, count read-only
    wr(A_MARK, 32'hFFFF_FFFF);
    rd(A_MARK, v); chk("R2 marker masked", v, 32'h0000_00FF);
    rd(A_CNT, c0); wr(A_CNT, 32'h55);
    rd(A_CNT, v); chk("R2 count write ignored", v, c0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule